// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-add that forms z + x*y, or z - x*y when the product-negation input is high. It sorts each of the three 32-bit operands into one of six classes: signalling NaN, quiet NaN, infinity, zero, subnormal or normal. When an operand or the product is special, it picks the final result itself and raises invalid-operation where the arithmetic has no defined value.

A bypass output tells the finite-arithmetic datapath behind it whether the result is already settled. When bypass is low, the datapath must produce the answer, and this block drives a zero result with no flag. The rounding-mode input affects only the sign of an exact zero that comes from adding zeros of opposite sign.

The three outputs are registered once, so they appear one clock after the operands are applied.

Top module: `fma_special_resolve`

## Requirements
- R1: While rst_n is low, res_q, invalid_q and bypass_q are all zero.
- R2: A signalling NaN has exponent all ones, mantissa nonzero and mantissa bit 22 clear. If any operand is a signalling NaN, the result is the first such operand in the order z, x, y, with bit 22 set. invalid_q and bypass_q are both high.
- R3: A signalling NaN in any operand wins over a quiet NaN in any other operand, including an earlier one in the z, x, y order.
- R4: A quiet NaN has exponent all ones and mantissa bit 22 set. When no operand is a signalling NaN and some operand is a quiet NaN, the first quiet NaN in the order z, x, y is returned bit for bit. bypass_q is high and invalid_q is low.
- R5: With no NaN present, if one of x and y is infinite and the other is zero, the result is the default NaN 0x7FC00000 and invalid_q is high.
- R6: The effective product sign is x[31]^y[31], inverted when neg_prod is high. With no NaN present, if the product is infinite and z is an infinity of the opposite sign, the result is 0x7FC00000 and invalid_q is high.
- R7: In every other case where the product is infinite, the result is infinity with the effective product sign, and invalid_q is low.
- R8: If the product is zero (neither factor infinite) and z is infinite, the result is z.
- R9: If the product and z are both zero and z's sign equals the effective product sign, the result is z.
- R10: If the product and z are both zero with opposite signs, the result is a zero. It is negative only when rnd_mode is 2'b11 (toward minus infinity).
- R11: If z is finite and nonzero and the product is zero, the result is z. The same holds if the product is finite and nonzero and z is infinite. invalid_q is low in both cases.
- R12: When none of the cases above applies, bypass_q is low, and res_q and invalid_q are zero. Subnormal operands count as finite and nonzero.
- R13: Every output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_z | input | 32 | Addend |
| op_x | input | 32 | First factor |
| op_y | input | 32 | Second factor |
| neg_prod | input | 1 | Negate the product |
| rnd_mode | input | 2 | Rounding mode, 2'b11 = toward minus infinity |
| res_q | output | 32 | Resolved result (zero when not bypassing) |
| invalid_q | output | 1 | Invalid-operation flag |
| bypass_q | output | 1 | Result decided here |

## Verification
Each result is due exactly one rising edge after its operands are applied. The bench drives a new operand set on every falling edge. On the next falling edge it compares all three outputs against the value its reference model computed for the set before. Directed vectors cover each NaN ordering, each infinity and zero sign case under both values of neg_prod, and both relevant rounding modes. A run of mixed random vectors, built from special values, subnormals and normals, then compares every cycle.

// File: rtl/fma_special_resolve.sv
module fma_special_resolve #(
  parameter int          EW      = 8,
  parameter int          FW      = 23,
  parameter logic [1:0]  RM_DOWN = 2'b11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EW+FW:0]       op_z,
  input  logic [EW+FW:0]       op_x,
  input  logic [EW+FW:0]       op_y,
  input  logic                 neg_prod,
  input  logic [1:0]           rnd_mode,
  output logic [EW+FW:0]       res_q,
  output logic                 invalid_q,
  output logic                 bypass_q
);
  localparam int W = EW + FW + 1;
  localparam logic [W-1:0] QBIT    = W'(1) << (FW - 1);
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [W-1:0] POS_INF = {1'b0, {EW{1'b1}}, {FW{1'b0}}};

  logic [2:0] is_snan, is_qnan, is_inf, is_zero;
  logic [W-1:0] ops [3];
  assign ops[0] = op_z;
  assign ops[1] = op_x;
  assign ops[2] = op_y;

  for (genvar i = 0; i < 3; i++) begin : g_cls
    wire e_max  = &ops[i][W-2:FW];
    wire e_min  = ~|ops[i][W-2:FW];
    wire f_nz   = |ops[i][FW-1:0];
    assign is_snan[i] = e_max & f_nz & ~ops[i][FW-1];
    assign is_qnan[i] = e_max & ops[i][FW-1];
    assign is_inf[i]  = e_max & ~f_nz;
    assign is_zero[i] = e_min & ~f_nz;
  end

  wire p_sign   = op_x[W-1] ^ op_y[W-1] ^ neg_prod;
  wire z_sign   = op_z[W-1];
  wire p_inf    = is_inf[1] | is_inf[2];
  wire p_zero   = is_zero[1] | is_zero[2];
  wire inf_zero = (is_inf[1] & is_zero[2]) | (is_zero[1] & is_inf[2]);

  logic [W-1:0] res_d;
  logic         inv_d, byp_d;

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    byp_d = 1'b1;
    if (is_snan[0]) begin
      res_d = op_z | QBIT; inv_d = 1'b1;
    end else if (is_snan[1]) begin
      res_d = op_x | QBIT; inv_d = 1'b1;
    end else if (is_snan[2]) begin
      res_d = op_y | QBIT; inv_d = 1'b1;
    end else if (is_qnan[0]) begin
      res_d = op_z;
    end else if (is_qnan[1]) begin
      res_d = op_x;
    end else if (is_qnan[2]) begin
      res_d = op_y;
    end else if (inf_zero) begin
      res_d = DEF_NAN; inv_d = 1'b1;
    end else if (p_inf) begin
      if (is_inf[0] && z_sign != p_sign) begin
        res_d = DEF_NAN; inv_d = 1'b1;
      end else begin
        res_d = POS_INF | {p_sign, {(W-1){1'b0}}};
      end
    end else if (p_zero) begin
      if (is_zero[0] && z_sign != p_sign)
        res_d = {rnd_mode == RM_DOWN, {(W-1){1'b0}}};
      else
        res_d = op_z;
    end else if (is_inf[0]) begin
      res_d = op_z;
    end else begin
      byp_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      invalid_q <= 1'b0;
      bypass_q  <= 1'b0;
    end else begin
      res_q     <= res_d;
      invalid_q <= inv_d;
      bypass_q  <= byp_d;
    end
  end
endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] op_z,
  input logic [31:0] op_x,
  input logic [31:0] op_y,
  input logic [31:0] res_q,
  input logic        invalid_q,
  input logic        bypass_q
);
  function automatic logic snan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0) && !v[22];
  endfunction
  function automatic logic qnan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && v[22];
  endfunction

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  AST_INVALID_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_q |-> bypass_q); // R12
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_q |-> (res_q == 32'h0 && !invalid_q)); // R12
  AST_SNAN_Z_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rst_n) && snan($past(op_z))) |-> (res_q == ($past(op_z) | 32'h0040_0000) && invalid_q)); // R2
  AST_QNAN_Z_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rst_n) && qnan($past(op_z)) && !snan($past(op_x)) && !snan($past(op_y)))
      |-> (res_q == $past(op_z) && !invalid_q)); // R4
  AST_INF_TIMES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rst_n) && $past(op_x[30:0]) == 31'h7F80_0000 && $past(op_y[30:0]) == 31'h0
      && !snan($past(op_z)) && !qnan($past(op_z)))
      |-> (res_q == 32'h7FC0_0000 && invalid_q)); // R5
endmodule

bind fma_special_resolve fma_special_resolve_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_z(op_z), .op_x(op_x), .op_y(op_y),
  .res_q(res_q), .invalid_q(invalid_q), .bypass_q(bypass_q)
);

// File: tb/sim_fma_special_resolve.sv
module sim_fma_special_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_z = '0, op_x = '0, op_y = '0;
  logic        neg_prod = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic [31:0] res_q;
  logic        invalid_q, bypass_q;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fma_special_resolve u0 (
    .clk(clk), .rst_n(rst_n), .op_z(op_z), .op_x(op_x), .op_y(op_y),
    .neg_prod(neg_prod), .rnd_mode(rnd_mode),
    .res_q(res_q), .invalid_q(invalid_q), .bypass_q(bypass_q)
  );

  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000, DNAN = 32'h7FC0_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000, SUB = 32'h0000_0003;
  localparam logic [31:0] SN1 = 32'h7F80_0001, SN2 = 32'hFFA0_0000, QN1 = 32'h7FC0_1234, QN2 = 32'hFFC0_0007;

  function automatic int kind(input logic [31:0] v);
    if (v[30:23] == 8'hFF) begin
      if (v[22:0] == 0) return 2;
      return v[22] ? 1 : 0;
    end
    if (v[30:0] == 0) return 3;
    return 4;
  endfunction

  task automatic model(input logic [31:0] z, x, y, input logic n, input logic [1:0] rm,
                       output logic [31:0] r, output logic inv, output logic byp);
    logic [31:0] v [3];
    logic ps;
    int kz, kx, ky;
    v[0] = z; v[1] = x; v[2] = y;
    r = 0; inv = 0; byp = 1;
    for (int k = 0; k < 3; k++)
      if (kind(v[k]) == 0) begin r = v[k] | 32'h0040_0000; inv = 1; return; end
    for (int k = 0; k < 3; k++)
      if (kind(v[k]) == 1) begin r = v[k]; return; end
    kz = kind(z); kx = kind(x); ky = kind(y);
    ps = x[31] ^ y[31] ^ n;
    if ((kx == 2 && ky == 3) || (kx == 3 && ky == 2)) begin r = DNAN; inv = 1; return; end
    if (kx == 2 || ky == 2) begin
      if (kz == 2 && z[31] != ps) begin r = DNAN; inv = 1; end
      else r = {ps, 31'h7F80_0000};
      return;
    end
    if (kx == 3 || ky == 3) begin
      if (kz == 3 && z[31] != ps) r = {rm == 2'b11, 31'h0};
      else r = z;
      return;
    end
    if (kz == 2) begin r = z; return; end
    byp = 0;
  endtask

  logic        pend = 0;
  string       ptag;
  logic [31:0] er;
  logic        ei, eb;

  task automatic compare();
    checks++;
    if (res_q !== er || invalid_q !== ei || bypass_q !== eb) begin
      errors++;
      $display("FAIL %s: got res=%h inv=%b byp=%b expected res=%h inv=%b byp=%b",
               ptag, res_q, invalid_q, bypass_q, er, ei, eb);
    end
  endtask

  task automatic apply(input logic [31:0] z, x, y, input logic n, input logic [1:0] rm, input string tag);
    @(negedge clk);
    if (pend) compare();
    op_z = z; op_x = x; op_y = y; neg_prod = n; rnd_mode = rm;
    model(z, x, y, n, rm, er, ei, eb);
    ptag = tag; pend = 1;
  endtask

  function automatic logic [31:0] pick(input int sel, input logic [31:0] rnd);
    case (sel % 8)
      0: return {rnd[31], 31'h7F80_0000};
      1: return {rnd[31], 31'h0};
      2: return {rnd[31], 8'hFF, 1'b1, rnd[21:0]};
      3: return {rnd[31], 8'hFF, 1'b0, rnd[21:1], 1'b1};
      4: return {rnd[31], 8'h00, rnd[22:0] | 23'h1};
      default: return {rnd[31], 8'h01 + {1'b0, rnd[29:23] & 7'h7D}, rnd[22:0]};
    endcase
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op_z = SN1; op_x = QN1; op_y = PINF;
    repeat (3) @(negedge clk);
    checks++;
    if (res_q !== 0 || invalid_q !== 0 || bypass_q !== 0) begin
      errors++;
      $display("FAIL R1: got res=%h inv=%b byp=%b expected 0 0 0", res_q, invalid_q, bypass_q);
    end
    rst_n = 1'b1;
    // R13 timing is exercised by every compare below: one edge per vector
    apply(SN1, SN2, ONE, 0, 0, "R2 snan z first");
    apply(ONE, SN2, SN1, 0, 0, "R2 snan x before y");
    apply(ONE, TWO, SN1, 0, 0, "R2 snan y");
    apply(QN1, ONE, SN2, 0, 0, "R3 snan y over qnan z");
    apply(QN1, SN1, ONE, 0, 0, "R3 snan x over qnan z");
    apply(QN1, QN2, ONE, 0, 0, "R4 qnan z first");
    apply(ONE, QN2, QN1, 0, 0, "R4 qnan x before y");
    apply(PINF, ONE, QN1, 0, 0, "R4 qnan y over inf");
    apply(ONE, PINF, PZ, 0, 0, "R5 inf times zero");
    apply(NINF, NZ, NINF, 1, 0, "R5 zero times inf");
    apply(NINF, PINF, ONE, 0, 0, "R6 +inf product minus inf");
    apply(PINF, PINF, ONE, 1, 0, "R6 negated product vs +inf");
    apply(PINF, PINF, ONE, 0, 0, "R7 same sign inf");
    apply(ONE, NINF, TWO, 0, 0, "R7 finite z neg product");
    apply(ONE, NINF, NINF, 1, 0, "R7 negate gives -inf");
    apply(SUB, PINF, SUB, 0, 0, "R7 subnormal factor");
    apply(NINF, PZ, ONE, 0, 0, "R8 zero product inf z");
    apply(NZ, NZ, ONE, 0, 0, "R9 both negative zero");
    apply(PZ, NZ, ONE, 1, 0, "R9 negated agrees");
    apply(PZ, NZ, ONE, 0, 2'b00, "R10 opposite nearest");
    apply(PZ, NZ, ONE, 0, 2'b11, "R10 opposite toward minus");
    apply(NZ, PZ, PZ, 0, 2'b11, "R10 -z +p toward minus");
    apply(NZ, PZ, PZ, 1, 2'b10, "R10 negated agrees up mode");
    apply(TWO, PZ, ONE, 0, 0, "R11 zero product finite z");
    apply(SUB, ONE, NZ, 1, 0, "R11 subnormal z");
    apply(NINF, ONE, TWO, 0, 0, "R11 finite product inf z");
    apply(ONE, TWO, ONE, 0, 0, "R12 normal passthrough");
    apply(SUB, SUB, SUB, 1, 2'b11, "R12 subnormals to datapath");
    apply(PINF, PINF, ONE, 0, 0, "R13 back to back 1");
    apply(ONE, TWO, ONE, 0, 0, "R13 back to back 2");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      apply(pick($urandom, a), pick($urandom, b), pick($urandom, c),
            1'($urandom), 2'($urandom), "R13 random");
    end
    @(negedge clk);
    if (pend) compare();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule